// File: doc/BRIEF.md
# Indexed Block-Access Register Target for SMBus

This block is a bus target that holds a small file of control bytes for the clock-generation logic around it. It runs on a fast system clock, oversamples the two bus lines, and recognises START, repeated START and STOP conditions. It answers one of two 7-bit addresses, chosen by a strap input that is captured once when the power-good input first goes high. The data line is driven open-drain: the block only ever pulls it low.

Every write carries a starting index and a byte count, followed by the data bytes. A read first sets the index with a short write, then a repeated START with the read bit. The target then returns a count byte, taken from a writable register, followed by register contents from the index onwards until the host answers with NACK. The index advances after each data byte and wraps from the last register back to register 0. The stored bytes are exposed in parallel to the control logic. Some locations are identifier bytes or reserved, and writes to them have no effect.

Top module: `smb_regfile_slave`

## Requirements
- R1: The target address is 7'h68 when `strap_addr` was 0 and 7'h6A when it was 1, sampled at the first rising edge of `pwr_good` after reset; later edges of `pwr_good` or changes of `strap_addr` do not change it.
- R2: An address byte that does not match is not acknowledged, and the target leaves SDA released for every following byte until the next START.
- R3: A write is address+W, index byte, count byte, then data bytes, each acknowledged. Data bytes are stored from the register selected by the index's low three bits. The index increments per byte and wraps from 7 to 0.
- R4: Data bytes beyond the byte count are not acknowledged and not stored.
- R5: A read (address+W, index, repeated START, address+R) returns first a count byte equal to register 7 bits 4:0, then register contents starting at the index with auto-increment, until the host NACKs.
- R6: After reset the registers hold: reg0 0xFF, reg1 0x00, reg2 0xFF, reg3 0x5F, reg4 0x00, reg5 0x11, reg6 0x08, reg7 0x08.
- R7: Writes to reg4, reg5 and reg6, to reg1 bits 7:6, and to reg7 bits 7:5 are acknowledged but discarded. Reads of reg1 bits 7:6 return `spread_sel`.
- R8: A START inside a transfer restarts address reception; a STOP returns the target to idle with SDA released; a byte cut short by either is not stored.
- R9: The target pulls SDA low only by starting while SCL is low: for an ACK during the ninth clock, and for read data bits set up after each SCL falling edge.
- R10: `regs_q` bits 8i+7:8i show the stored byte of register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When high, the pad pulls the data line low |
| strap_addr | input | 1 | Address strap, selects one of two addresses |
| pwr_good | input | 1 | Power-good input; its first rising edge latches the strap |
| spread_sel | input | 2 | Spread setting shown in reg1 bits 7:6 on reads |
| regs_q | output | 64 | Parallel copy of the eight stored register bytes |

## Verification
The hardest case to reach is a transfer cut short in the middle of a byte. The bus model in the bench can stop clocking after a chosen number of bits and then issue a repeated START or a STOP. Those partial bytes must leave no trace in the registers. A further write or read then checks that the target is still in step with the bus. Index wrap-around and the bytes past the count are reached by starting writes at register 7 and by sending one data byte more than the count.

// File: rtl/smb_regfile_slave.sv
module smb_regfile_slave #(
  parameter int               NREG    = 8,
  parameter int               CNT_W   = 5,
  parameter int               RB_REG  = 1,
  parameter logic [6:0]       ADDR_LO = 7'h68,
  parameter logic [6:0]       ADDR_HI = 7'h6A,
  parameter logic [NREG*8-1:0] RST_VAL = 64'h0808_1100_5FFF_00FF,
  parameter logic [NREG*8-1:0] WR_MASK = 64'h1F00_0000_FFFF_3FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic              strap_addr,
  input  logic              pwr_good,
  input  logic [1:0]        spread_sel,
  output logic [NREG*8-1:0] regs_q
);
  localparam int IDX_W = $clog2(NREG);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NREG - 1);

  typedef enum logic [2:0] {IDLE, RX, RX_END, RX_ACK, TX, TX_ACK, SKIP} st_t;
  typedef enum logic [1:0] {K_ADDR, K_IDX, K_CNT, K_DATA} kind_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic       pg_d, strap_done, addr_sel;
  st_t        st;
  kind_t      kind;
  logic [2:0] bitcnt;
  logic [7:0] sr, txsr, wrem;
  logic       rnw, hack, take;
  logic [IDX_W-1:0] ptr;
  logic [7:0] regs [NREG];
  logic [7:0] rdv, wmask;

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire bus_start = scl_s & scl_d & sda_d & ~sda_s;
  wire bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
  wire [6:0] my_addr = addr_sel ? ADDR_HI : ADDR_LO;
  wire [IDX_W-1:0] ptr_nx = (ptr == LAST) ? '0 : ptr + 1'b1;
  wire [7:0] cnt_byte = 8'(regs[NREG-1][CNT_W-1:0]);

  assign wmask = WR_MASK[int'(ptr)*8 +: 8];

  always_comb begin
    rdv = regs[ptr];
    if (int'(ptr) == RB_REG) rdv[7:6] = spread_sel;
  end

  always_comb begin
    case (kind)
      K_ADDR:  take = (sr[7:1] == my_addr);
      K_DATA:  take = (wrem != 8'd0);
      default: take = 1'b1;
    endcase
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_q[g*8 +: 8] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_d <= 1'b0; strap_done <= 1'b0; addr_sel <= 1'b0;
    end else begin
      pg_d <= pwr_good;
      if (pwr_good && !pg_d && !strap_done) begin
        addr_sel   <= strap_addr;
        strap_done <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; kind <= K_ADDR; bitcnt <= '0; sr <= '0; txsr <= '0;
      wrem <= '0; rnw <= 1'b0; hack <= 1'b0; ptr <= '0; sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= RST_VAL[i*8 +: 8];
    end else if (bus_start) begin
      st <= RX; kind <= K_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
    end else if (bus_stop) begin
      st <= IDLE; sda_oe <= 1'b0;
    end else begin
      case (st)
        RX: if (scl_rise) begin
          sr     <= {sr[6:0], sda_s};
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) st <= RX_END;
        end
        RX_END: if (scl_fall) begin
          if (take) begin
            sda_oe <= 1'b1;
            st     <= RX_ACK;
            case (kind)
              K_ADDR: begin rnw <= sr[0]; kind <= K_IDX; end
              K_IDX:  begin ptr <= sr[IDX_W-1:0]; kind <= K_CNT; end
              K_CNT:  begin wrem <= sr; kind <= K_DATA; end
              default: begin
                regs[ptr] <= (regs[ptr] & ~wmask) | (sr & wmask);
                ptr  <= ptr_nx;
                wrem <= wrem - 8'd1;
              end
            endcase
          end else begin
            st <= SKIP;
          end
        end
        RX_ACK: if (scl_fall) begin
          bitcnt <= '0;
          if (rnw) begin
            st <= TX; txsr <= cnt_byte; sda_oe <= ~cnt_byte[7];
          end else begin
            st <= RX; sda_oe <= 1'b0;
          end
        end
        TX: if (scl_fall) begin
          if (bitcnt == 3'd7) begin
            sda_oe <= 1'b0; st <= TX_ACK;
          end else begin
            sda_oe <= ~txsr[3'd6 - bitcnt];
            bitcnt <= bitcnt + 3'd1;
          end
        end
        TX_ACK: begin
          if (scl_rise) hack <= ~sda_s;
          if (scl_fall) begin
            if (hack) begin
              st <= TX; txsr <= rdv; sda_oe <= ~rdv[7]; bitcnt <= '0; ptr <= ptr_nx;
            end else begin
              st <= SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smb_regfile_slave_chk.sv
module smb_regfile_slave_chk #(
  parameter int               NREG    = 8,
  parameter logic [NREG*8-1:0] WR_MASK = 64'h1F00_0000_FFFF_3FFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_in,
  input logic              sda_oe,
  input logic [NREG*8-1:0] regs_q,
  input logic              strap_done,
  input logic              addr_sel
);
  p_drive_low_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_in);

  p_store_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_q) |-> !scl_in);

  p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strap_done) |-> $stable(addr_sel));

  for (genvar g = 0; g < NREG; g++) begin : g_ro
    if (WR_MASK[g*8 +: 8] == 8'h00) begin : g_on
      p_ro_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(regs_q[g*8 +: 8]));
    end
  end
endmodule

bind smb_regfile_slave smb_regfile_slave_chk #(.NREG(NREG), .WR_MASK(WR_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
  .regs_q(regs_q), .strap_done(strap_done), .addr_sel(addr_sel)
);

// File: tb/smb_regfile_slave_test.sv
module smb_regfile_slave_test;
  localparam int Q = 25;
  localparam logic [63:0] RST = 64'h0808_1100_5FFF_00FF;

  logic clk = 0, rst_n = 0, scl = 1, sda_h = 1, strap = 0, pg = 0;
  logic [1:0] spread = 2'b00;
  logic sda_oe;
  logic [63:0] regs_q;
  wire sda_line = sda_h & ~sda_oe;
  int nchk = 0, nerr = 0;
  int oe_events = 0, oe_hi_scl = 0;
  logic oe_prev = 0;

  always #2.5 clk = ~clk;

  smb_regfile_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .strap_addr(strap), .pwr_good(pg), .spread_sel(spread), .regs_q(regs_q)
  );

  always @(posedge clk) begin
    oe_prev <= sda_oe;
    if (sda_oe && !oe_prev) begin
      oe_events <= oe_events + 1;
      if (scl) oe_hi_scl <= oe_hi_scl + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic bstart();
    sda_h = 1; qw(); scl = 1; qw(); sda_h = 0; qw(); scl = 0; qw();
  endtask

  task automatic bstop();
    sda_h = 0; qw(); scl = 1; qw(); sda_h = 1; qw();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; qw(); scl = 1; qw(); qw(); scl = 0; qw();
    end
    sda_h = 1; qw(); scl = 1; qw(); ack = ~sda_line; qw(); scl = 0; qw();
  endtask

  task automatic part_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_h = b[i]; qw(); scl = 1; qw(); qw(); scl = 0; qw();
    end
  endtask

  task automatic rd_byte(output logic [7:0] b, input logic last);
    sda_h = 1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl = 1; qw(); b[i] = sda_line; qw(); scl = 0;
    end
    qw(); sda_h = last; qw(); scl = 1; qw(); qw(); scl = 0; qw(); sda_h = 1;
  endtask

  task automatic write_txn(input logic [6:0] a, input logic [7:0] idx, input logic [7:0] cnt,
                           input logic [63:0] dat, input int n, output logic [15:0] acks);
    logic k;
    acks = '0;
    bstart();
    wr_byte({a, 1'b0}, k); acks[0] = k;
    wr_byte(idx, k); acks[1] = k;
    wr_byte(cnt, k); acks[2] = k;
    for (int i = 0; i < n; i++) begin wr_byte(dat[8*i +: 8], k); acks[3+i] = k; end
    bstop();
  endtask

  task automatic read_txn(input logic [6:0] a, input logic [7:0] idx, input int n,
                          output logic [7:0] cb, output logic [63:0] dat, output logic [2:0] acks);
    logic k;
    logic [7:0] x;
    dat = '0;
    bstart();
    wr_byte({a, 1'b0}, k); acks[0] = k;
    wr_byte(idx, k); acks[1] = k;
    bstart();
    wr_byte({a, 1'b1}, k); acks[2] = k;
    rd_byte(cb, 1'b0);
    for (int i = 0; i < n; i++) begin rd_byte(x, i == n - 1); dat[8*i +: 8] = x; end
    bstop();
  endtask

  task automatic do_reset(input logic s);
    rst_n = 0; strap = s; pg = 0; scl = 1; sda_h = 1;
    repeat (10) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R6 reset registers", regs_q, RST);
    chk("R9 released after reset", 64'(sda_oe), 64'd0);
    pg = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_write();
    logic [15:0] a;
    write_txn(7'h68, 8'h00, 8'd3, 64'hC3_55_AA, 3, a);
    chk("R3 write acks", 64'(a), 64'h3F);
    chk("R10 reg0 at bits 7:0", 64'(regs_q[7:0]), 64'hAA);
    chk("R7 reg1 bits 7:6 not stored", 64'(regs_q[15:8]), 64'h15);
    chk("R3 reg2 stored", 64'(regs_q[23:16]), 64'hC3);
    chk("R3 reg3 untouched", 64'(regs_q[31:24]), 64'h5F);
  endtask

  task automatic t_read();
    logic [7:0] cb; logic [63:0] d; logic [2:0] a;
    spread = 2'b10;
    read_txn(7'h68, 8'h00, 3, cb, d, a);
    chk("R5 read acks", 64'(a), 64'h7);
    chk("R5 count byte", 64'(cb), 64'h08);
    chk("R5 read data", d, 64'hC3_95_AA);
  endtask

  task automatic t_ro();
    logic [15:0] a; logic [7:0] cb; logic [63:0] d; logic [2:0] ra;
    write_txn(7'h68, 8'h04, 8'd4, 64'hE3_33_22_11, 4, a);
    chk("R7 protected writes acked", 64'(a), 64'h7F);
    chk("R7 reg4..6 unchanged", 64'(regs_q[55:32]), 64'h08_11_00);
    chk("R7 reg7 upper bits dropped", 64'(regs_q[63:56]), 64'h03);
    read_txn(7'h68, 8'h05, 2, cb, d, ra);
    chk("R5 count follows reg7", 64'(cb), 64'h03);
    chk("R5 id bytes read", d, 64'h08_11);
  endtask

  task automatic t_wrap();
    logic [15:0] a; logic [7:0] cb; logic [63:0] d; logic [2:0] ra;
    write_txn(7'h68, 8'h07, 8'd2, 64'h77_04, 2, a);
    chk("R3 wrap acks", 64'(a), 64'h1F);
    chk("R3 wrap reg7", 64'(regs_q[63:56]), 64'h04);
    chk("R3 wrap reg0", 64'(regs_q[7:0]), 64'h77);
    read_txn(7'h68, 8'h06, 3, cb, d, ra);
    chk("R5 wrap count", 64'(cb), 64'h04);
    chk("R5 wrap read", d, 64'h77_04_08);
  endtask

  task automatic t_over();
    logic [15:0] a;
    write_txn(7'h68, 8'h02, 8'd1, 64'h34_12, 2, a);
    chk("R4 extra byte nacked", 64'(a), 64'h0F);
    chk("R4 reg2 written", 64'(regs_q[23:16]), 64'h12);
    chk("R4 reg3 not written", 64'(regs_q[31:24]), 64'h5F);
  endtask

  task automatic t_wrong_addr();
    logic [15:0] a; logic [7:0] cb; logic [63:0] d; logic [2:0] ra;
    int ev;
    ev = oe_events;
    write_txn(7'h6A, 8'h00, 8'd2, 64'h99_99, 2, a);
    chk("R2 no ack for other address", 64'(a), 64'h0);
    chk("R2 SDA never driven", 64'(oe_events - ev), 64'd0);
    chk("R2 reg0 unchanged", 64'(regs_q[7:0]), 64'h77);
    read_txn(7'h68, 8'h00, 1, cb, d, ra);
    chk("R2 next START answered", 64'(ra), 64'h7);
    chk("R2 read after mismatch", d, 64'h77);
  endtask

  task automatic t_abort();
    logic k; logic [15:0] a; logic [7:0] cb; logic [63:0] d; logic [2:0] ra;
    bstart();
    wr_byte(8'hD0, k); wr_byte(8'h03, k); wr_byte(8'h02, k);
    part_bits(8'hA5, 4);
    write_txn(7'h68, 8'h01, 8'd1, 64'h3C, 1, a);
    chk("R8 restart acks", 64'(a), 64'h0F);
    chk("R8 partial byte not stored", 64'(regs_q[31:24]), 64'h5F);
    chk("R8 write after restart", 64'(regs_q[15:8]), 64'h3C);
    bstart();
    wr_byte(8'hD0, k); wr_byte(8'h02, k);
    part_bits(8'hFF, 5);
    bstop();
    repeat (5) @(negedge clk);
    chk("R8 SDA released after STOP", 64'(sda_oe), 64'd0);
    read_txn(7'h68, 8'h02, 1, cb, d, ra);
    chk("R8 reg2 kept after STOP", d, 64'h12);
  endtask

  task automatic t_strap();
    logic [15:0] a; logic [7:0] cb; logic [63:0] d; logic [2:0] ra;
    strap = 1; pg = 0; repeat (10) @(negedge clk); pg = 1; repeat (10) @(negedge clk);
    read_txn(7'h68, 8'h00, 1, cb, d, ra);
    chk("R1 strap held after later edge", 64'(ra), 64'h7);
    do_reset(1'b1);
    write_txn(7'h68, 8'h00, 8'd1, 64'h11, 1, a);
    chk("R1 low address ignored", 64'(a), 64'h0);
    write_txn(7'h6A, 8'h00, 8'd1, 64'h5A, 1, a);
    chk("R1 high address acks", 64'(a), 64'h0F);
    chk("R1 high address write", 64'(regs_q[7:0]), 64'h5A);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    t_write();
    t_read();
    t_ro();
    t_wrap();
    t_over();
    t_wrong_addr();
    t_abort();
    t_strap();
    chk("R9 SDA pulled only while SCL low", 64'(oe_hi_scl), 64'd0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule